// File: doc/BRIEF.md
# Inverter Fault Protection Latch

This block guards a three-phase inverter bridge. Four digital fault inputs come in: a low-side switch fault, an over-current flag, an over-voltage flag and a level that says the motor runs above its high speed threshold. The block resolves them into a 4-bit trip code that the PWM stage uses to override its half-bridge outputs. The three protective choices are shutting every switch off, shorting the three low-side switches, or shorting the three high-side switches. When speed is low, every fault means shutdown. When speed is high, an over-voltage selects one of the two short-circuit states. The switch-fault input decides which side is shorted.

The block resolves a fault through a 16-entry table indexed by the synchronized input vector. The table can be rewritten by the host. Once a protective code is picked, the block can hold the bridge fully off for a programmed freewheel interval. It then applies the code and keeps it latched, and fault inputs are ignored from then on. The code is mirrored in a status register until the host writes a nonzero clear request. The clear returns the outputs to normal and re-arms the block. Re-arming is also when the freewheel interval is reloaded.

Top module: `trip_latch`

## Requirements
- R1: Trip code bits: bit 0 forces output A high, bit 1 forces A low, bit 2 forces B high and bit 3 forces B low. All-off is 0xA, low-side short is 0x6 and high-side short is 0x9. After reset, `tripOut` is 0 and the status register reads 0.
- R2: The table index is {speedHigh, overVolt, overCurr, swFault}, with bit 3 first. In the default table with speedHigh=0, overCurr or overVolt gives 0xA. With neither present the result is 0, whatever swFault is.
- R3: In the default table with speedHigh=1, overVolt gives 0x6 when swFault=0 and 0x9 when swFault=1, whatever overCurr is. overCurr alone gives 0xA. No fault gives 0.
- R4: An all-zero input vector, or a table entry of 0, causes no trip, and monitoring continues.
- R5: An input change is reflected on `tripOut` after the third rising clock edge. After the second edge it has no effect yet.
- R6: With an armed freewheel count N>0, `tripOut` reads 0xA and the status reads 0 for N cycles, and then the code is applied. With N=0 the code is applied at once.
- R7: The freewheel register is at address 18 and is 32 bits wide, counted in clock cycles. A write to it takes effect only when the block is next re-armed by a clear. The reset value is the parameter default.
- R8: Once applied, the code stays on `tripOut` and in the status register at address 16, and later input changes are ignored.
- R9: A nonzero write to the clear register at address 17 is held and reads back until it is serviced. At the next edge `tripOut`, the status and the clear register become 0 and monitoring resumes. Writing 0 has no effect.
- R10: Table entries sit at addresses 0 to 15. Only the low 4 bits are stored, and the entries read back as written. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| swFault | input | 1 | Low-side switch fault, asynchronous |
| overCurr | input | 1 | Over-current flag, asynchronous |
| overVolt | input | 1 | Over-voltage flag, asynchronous |
| speedHigh | input | 1 | Speed above high threshold, asynchronous |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data, combinational on regAddr |
| tripOut | output | 4 | Trip code to the PWM override |

## Verification
The bench sweeps all sixteen input vectors against an arithmetic decision model. A wrong table entry would short the wrong side or leave a fault unprotected. It changes the inputs while the code is latched, to catch a latch that follows the inputs and re-trips. The freewheel cases count the exact number of all-off cycles, check that a count of zero skips the phase, and show that a new freewheel value waits for a re-arm. An off-by-one counter, or a live reload from the register, would each give the wrong timing. Zero-valued clear writes and rewritten table entries are also tested, to catch a design that clears on any write or ignores host table updates.

// File: rtl/trip_pkg.sv
package trip_pkg;

  typedef struct packed {
    logic startFw;
    logic applyDirect;
    logic tick;
    logic applyHeld;
    logic clearAll;
  } tripStrobe_t;

  typedef enum logic [1:0] {
    ST_WATCH = 2'd0,
    ST_FREE  = 2'd1,
    ST_HOLD  = 2'd2
  } tripState_t;

  localparam int CODE_W      = 4;
  localparam int LUT_DEPTH   = 16;
  localparam int ADDR_STATUS = 16;
  localparam int ADDR_CLEAR  = 17;
  localparam int ADDR_FREE   = 18;
  localparam int CLR_W       = 8;

  localparam logic [CODE_W-1:0] CODE_OFF  = 4'hA;
  localparam logic [CODE_W-1:0] CODE_LOW  = 4'h6;
  localparam logic [CODE_W-1:0] CODE_HIGH = 4'h9;

  // Index bits: 3 speedHigh, 2 overVolt, 1 overCurr, 0 swFault
  function automatic logic [CODE_W-1:0] defaultTrip(input logic [3:0] idx);
    logic [CODE_W-1:0] code;
    code = '0;
    if (!idx[3]) begin
      if (idx[1] || idx[2]) code = CODE_OFF;
    end else if (idx[2]) begin
      code = idx[0] ? CODE_HIGH : CODE_LOW;
    end else if (idx[1]) begin
      code = CODE_OFF;
    end
    return code;
  endfunction

endpackage

// File: rtl/trip_datapath.sv
module trip_datapath
  import trip_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int FW_RESET = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        faultIn,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  tripStrobe_t       strobe,
  output logic              hit,
  output logic              armedZero,
  output logic              cntLast,
  output logic              clrPending,
  output logic [CODE_W-1:0] tripOut
);

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADDR_STATUS);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(ADDR_CLEAR);
  localparam logic [ADDR_W-1:0] A_FREE   = ADDR_W'(ADDR_FREE);
  localparam logic [ADDR_W-1:0] A_LUTEND = ADDR_W'(LUT_DEPTH);

  logic [3:0]        syncA, syncB;
  logic [CODE_W-1:0] lut [LUT_DEPTH];
  logic [CODE_W-1:0] curEntry;
  logic [CODE_W-1:0] heldCode, statusReg, tripReg;
  logic [CNT_W-1:0]  fwReg, armedCnt, cnt;
  logic [CLR_W-1:0]  clrReq;
  logic              lutSel;

  assign lutSel = regAddr < A_LUTEND;

  // Programmable decision table, one register per entry
  for (genvar gi = 0; gi < LUT_DEPTH; gi++) begin : g_lut
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) lut[gi] <= defaultTrip(4'(gi));
      else if (regWe && lutSel && regAddr[3:0] == 4'(gi))
        lut[gi] <= regWdata[CODE_W-1:0];
    end
  end

  assign curEntry   = lut[syncB];
  assign hit        = (syncB != '0) && (curEntry != '0);
  assign armedZero  = armedCnt == '0;
  assign cntLast    = cnt == CNT_W'(1);
  assign clrPending = clrReq != '0;
  assign tripOut    = tripReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA     <= '0;
      syncB     <= '0;
      tripReg   <= '0;
      statusReg <= '0;
      heldCode  <= '0;
      cnt       <= '0;
      armedCnt  <= CNT_W'(FW_RESET);
      fwReg     <= CNT_W'(FW_RESET);
      clrReq    <= '0;
    end else begin
      syncA <= faultIn;
      syncB <= syncA;
      if (regWe && regAddr == A_FREE) fwReg <= regWdata[CNT_W-1:0];
      if (strobe.clearAll) begin
        tripReg   <= '0;
        statusReg <= '0;
        clrReq    <= '0;
        armedCnt  <= fwReg;
      end else if (regWe && regAddr == A_CLEAR) begin
        clrReq <= regWdata[CLR_W-1:0];
      end
      if (strobe.startFw) begin
        tripReg  <= CODE_OFF;
        cnt      <= armedCnt;
        heldCode <= curEntry;
      end
      if (strobe.tick) cnt <= cnt - CNT_W'(1);
      if (strobe.applyDirect) begin
        tripReg   <= curEntry;
        statusReg <= curEntry;
        heldCode  <= curEntry;
      end
      if (strobe.applyHeld) begin
        tripReg   <= heldCode;
        statusReg <= heldCode;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (lutSel) regRdata = DATA_W'(lut[regAddr[3:0]]);
    else if (regAddr == A_STATUS) regRdata = DATA_W'(statusReg);
    else if (regAddr == A_CLEAR) regRdata = DATA_W'(clrReq);
    else if (regAddr == A_FREE) regRdata = DATA_W'(fwReg);
  end

endmodule

// File: rtl/trip_ctrl.sv
module trip_ctrl
  import trip_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hit,
  input  logic        armedZero,
  input  logic        cntLast,
  input  logic        clrPending,
  output tripStrobe_t strobe
);

  tripState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_WATCH;
    else state <= stateNxt;
  end

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    unique case (state)
      ST_WATCH: begin
        if (hit) begin
          if (armedZero) begin
            strobe.applyDirect = 1'b1;
            stateNxt = ST_HOLD;
          end else begin
            strobe.startFw = 1'b1;
            stateNxt = ST_FREE;
          end
        end
      end
      ST_FREE: begin
        if (cntLast) begin
          strobe.applyHeld = 1'b1;
          stateNxt = ST_HOLD;
        end else begin
          strobe.tick = 1'b1;
        end
      end
      ST_HOLD: begin
        if (clrPending) begin
          strobe.clearAll = 1'b1;
          stateNxt = ST_WATCH;
        end
      end
      default: stateNxt = ST_WATCH;
    endcase
  end

endmodule

// File: rtl/trip_latch.sv
module trip_latch
  import trip_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int FW_RESET = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swFault,
  input  logic              overCurr,
  input  logic              overVolt,
  input  logic              speedHigh,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [3:0]        tripOut
);

  tripStrobe_t strobe;
  logic        hit, armedZero, cntLast, clrPending;

  trip_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .FW_RESET(FW_RESET)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .faultIn({speedHigh, overVolt, overCurr, swFault}),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .strobe(strobe), .hit(hit), .armedZero(armedZero), .cntLast(cntLast),
    .clrPending(clrPending), .tripOut(tripOut)
  );

  trip_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .hit(hit), .armedZero(armedZero),
    .cntLast(cntLast), .clrPending(clrPending), .strobe(strobe)
  );

endmodule

// File: rtl/trip_latch_chk.sv
module trip_latch_chk
  import trip_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  tripOut,
  input tripStrobe_t strobe,
  input logic        clrPending
);

  // R6: entering freewheel drives all switches off
  a_r6_free_off: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startFw |=> tripOut == CODE_OFF);

  // R8: without an update strobe the trip output holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.startFw || strobe.applyDirect || strobe.applyHeld || strobe.clearAll)
      |=> $stable(tripOut));

  // R9: servicing a clear zeroes output and request
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (tripOut == '0) && !clrPending);

  // R9: a pending request stays until serviced
  a_r9_pending: assert property (@(posedge clk) disable iff (!rstN)
    (clrPending && !strobe.clearAll) |=> clrPending);

  // R1: control issues at most one action per cycle
  a_r1_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

endmodule

bind trip_latch trip_latch_chk chk_i (
  .clk(clk), .rstN(rstN), .tripOut(tripOut), .strobe(strobe), .clrPending(clrPending)
);

// File: tb/trip_latch_tb.sv
module trip_latch_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swFault = 0, overCurr = 0, overVolt = 0, speedHigh = 0;
  logic regWe = 0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [DATA_W-1:0] regRdata;
  logic [3:0] tripOut;

  int checks = 0;
  int errors = 0;

  trip_latch dut_i (
    .clk(clk), .rstN(rstN), .swFault(swFault), .overCurr(overCurr),
    .overVolt(overVolt), .speedHigh(speedHigh), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .tripOut(tripOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] model(input logic [3:0] v);
    logic sp, ov, oc, sw;
    {sp, ov, oc, sw} = v;
    if (!sp) return (oc | ov) ? 4'hA : 4'h0;
    if (ov)  return sw ? 4'h9 : 4'h6;
    if (oc)  return 4'hA;
    return 4'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic stepN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setVec(input logic [3:0] v);
    {speedHigh, overVolt, overCurr, swFault} = v;
  endtask

  task automatic regWrite(input int a, input logic [31:0] d);
    regWe = 1'b1; regAddr = ADDR_W'(a); regWdata = d;
    stepN(1);
    regWe = 1'b0;
  endtask

  task automatic regRead(input int a, output logic [31:0] d);
    regAddr = ADDR_W'(a);
    #1;
    d = regRdata;
  endtask

  task automatic clearTrip();
    setVec(4'h0);
    stepN(3);
    regWrite(17, 32'h1);
    stepN(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    stepN(3);
    rstN = 1'b1;
    stepN(1);
    chk("R1 reset tripOut", 32'(tripOut), 0);
    regRead(16, rd); chk("R1 reset status", rd, 0);
    regRead(17, rd); chk("R9 reset clear reg", rd, 0);
    regRead(18, rd); chk("R7 reset freewheel", rd, 0);
    regRead(5, rd);  chk("R10 default entry 5", rd, 32'hA);
    regRead(25, rd); chk("R10 unused address", rd, 0);

    // Exhaustive sweep of the default decision table (R2, R3, R4, R5, R8, R9)
    for (int i = 0; i < 16; i++) begin
      logic [3:0] exp;
      exp = model(4'(i));
      setVec(4'(i));
      stepN(2);
      chk("R5 no change after two edges", 32'(tripOut), 0);
      stepN(1);
      chk(i[3] ? "R3 high speed decision" : "R2 low speed decision", 32'(tripOut), 32'(exp));
      if (exp != 0) begin
        regRead(16, rd); chk("R8 status mirrors code", rd, 32'(exp));
        setVec(~4'(i));
        stepN(4);
        chk("R8 inputs ignored while latched", 32'(tripOut), 32'(exp));
        setVec(4'h0);
        stepN(3);
        regWrite(17, 32'h3C);
        regRead(17, rd); chk("R9 clear request held", rd, 32'h3C);
        stepN(1);
        chk("R9 trip released", 32'(tripOut), 0);
        regRead(16, rd); chk("R9 status zeroed", rd, 0);
        regRead(17, rd); chk("R9 clear reg zeroed", rd, 0);
      end else begin
        stepN(3);
        chk("R4 no trip for zero entry", 32'(tripOut), 0);
        setVec(4'h0);
        stepN(3);
      end
    end

    // Zero clear write has no effect (R9)
    setVec(4'hA);
    stepN(3);
    chk("R3 overcurrent alone at speed", 32'(tripOut), 32'hA);
    regWrite(17, 32'h0);
    stepN(3);
    chk("R9 zero clear ignored", 32'(tripOut), 32'hA);
    clearTrip();

    // Freewheel reload only at re-arm (R7, R6)
    regWrite(18, 32'd5);
    regRead(18, rd); chk("R7 freewheel readback", rd, 5);
    setVec(4'hC);
    stepN(3);
    chk("R7 new count not yet armed", 32'(tripOut), 32'h6);
    clearTrip();
    setVec(4'hD);
    stepN(3);
    for (int k = 0; k < 5; k++) begin
      chk("R6 freewheel all off", 32'(tripOut), 32'hA);
      regRead(16, rd); chk("R6 status zero during freewheel", rd, 0);
      stepN(1);
    end
    chk("R6 code after freewheel", 32'(tripOut), 32'h9);
    regRead(16, rd); chk("R6 status after freewheel", rd, 32'h9);
    clearTrip();
    regWrite(18, 32'd0);
    setVec(4'h2);
    stepN(8);
    chk("R6 low speed overcurrent", 32'(tripOut), 32'hA);
    clearTrip();
    setVec(4'hC);
    stepN(3);
    chk("R6 zero count skips freewheel", 32'(tripOut), 32'h6);
    clearTrip();

    // Writable table (R10, R4)
    regWrite(1, 32'h6);
    regRead(1, rd); chk("R10 entry readback", rd, 32'h6);
    regWrite(2, 32'hF3);
    regRead(2, rd); chk("R10 low bits only", rd, 32'h3);
    setVec(4'h1);
    stepN(3);
    chk("R10 rewritten entry applied", 32'(tripOut), 32'h6);
    clearTrip();
    regWrite(12, 32'h0);
    setVec(4'hC);
    stepN(6);
    chk("R4 zeroed entry no trip", 32'(tripOut), 0);
    setVec(4'h0);
    stepN(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule